// File: doc/BRIEF.md
# Uplink Symbol Dispatcher with Guard Stripping

This block sits after the front-end FFT engine of an uplink receiver. Every frequency-domain symbol arrives as a packet of samples on a single stream, tagged on its first sample with the receive antenna and the destination processing core. The block splits each packet into a left guard region, a useful band and a right guard region, using lengths held on configuration inputs. It throws the guard samples away in hardware, so the downstream buffers hold only the useful subcarriers.

The block tracks the position of each symbol inside its slot, counting separately for every antenna. The pilot symbol of the slot goes to the chosen core's pilot queue. Every other symbol goes to that core's data queue. After the last useful sample of a symbol has been handed over, the block posts a completion word on the chosen core's notification queue. A packet whose core id lies outside the configured core count is swallowed whole and sets a sticky error flag.

The queues use valid/ready handshakes. Samples and notification words travel on shared buses, with one valid and one ready per core and per queue.

Top module: `ul_symbol_dispatch`

## Requirements
- R1: Samples at packet positions below `cfgLeft`, and from `cfgLeft+cfgUseful` up to the packet end, never reach any queue. They are always accepted (`inReady`=1), whatever the state of the queues.
- R2: A useful sample appears on `outSample` unchanged, in arrival order, with the valid of exactly one queue raised.
- R3: A symbol with slot index 3 is written to the pilot queue of its core. Every other index is written to the data queue. The core is the `inCoreId` sampled with `inSop`.
- R4: Each antenna keeps its own slot index, counting 0 to 6 and wrapping to 0. A packet whose first sample has `inSlotStart`=1 takes index 0, and the next packet of that antenna takes index 1.
- R5: One cycle after the last useful sample is accepted, `ntfValid` of the destination core rises. `ntfWord` is {antenna[1:0], slot index[2:0], core[1:0]}. Both are held until `ntfReady` of that core is seen high.
- R6: For a useful sample, `inReady` equals the ready of the selected queue, and no other queue valid is raised.
- R7: While a completion word is still pending, useful samples of the next symbol are not offered (`inReady`=0, no queue valid). Guard samples still flow.
- R8: A packet with `inCoreId` >= `cfgCoreCount` is accepted without stalls and discarded entirely, with no notification. It sets `errBadCore`, which then stays high until reset. The slot index of its antenna still advances.
- R9: After reset, all queue valids, `ntfValid` and `errBadCore` are low, and the slot indexes restart at 0.
- R10: Guard lengths of zero are supported, so that a packet may consist of useful samples only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLeft | input | LEN_W | Left guard length in samples |
| cfgUseful | input | LEN_W | Useful band length in samples (at least 1) |
| cfgRight | input | LEN_W | Right guard length in samples |
| cfgCoreCount | input | CORE_W+1 | Number of cores that may be addressed |
| inValid | input | 1 | Input sample valid |
| inReady | output | 1 | Input sample accepted |
| inSop | input | 1 | First sample of a symbol packet |
| inSlotStart | input | 1 | With inSop: this symbol opens a new slot |
| inAntId | input | ANT_W | Antenna of the packet, read with inSop |
| inCoreId | input | CORE_W | Destination core, read with inSop |
| inData | input | SAMPLE_W | Sample value |
| dataValid | output | NUM_CORES | Data queue valid, one per core |
| dataReady | input | NUM_CORES | Data queue ready, one per core |
| pilotValid | output | NUM_CORES | Pilot queue valid, one per core |
| pilotReady | input | NUM_CORES | Pilot queue ready, one per core |
| outSample | output | SAMPLE_W | Sample bus shared by all data and pilot queues |
| ntfValid | output | NUM_CORES | Notification valid, one per core |
| ntfReady | input | NUM_CORES | Notification ready, one per core |
| ntfWord | output | ANT_W+3+CORE_W | Completion word |
| errBadCore | output | 1 | Sticky out-of-range core error |

## Verification
The bench uses the default four cores and four antennas, with 16-bit samples. The guard and useful lengths are cut to a few samples, 3/5/2 and then 0/4/0, so that every packet position, every antenna and core pairing, and every slot index from 0 to 6, including a wrap and a forced slot restart, is walked through within a few thousand cycles. A second sweep drives the queue readies from an arithmetic pattern, which covers stalls on the selected queue, guard samples passing during stalls, and notifications held back while the next symbol waits. Lowering the core count to three makes core 3 out of range, which exercises the drop path.

// File: rtl/usd_pkg.sv
package usd_pkg;
  // Per-sample strobes from control to datapath
  typedef struct packed {
    logic sop;         // first sample of packet accepted
    logic usefulGood;  // current sample is useful and packet is routable
    logic lastUseful;  // current sample is the last useful one
    logic fire;        // current sample accepted
    logic badStart;    // first sample of an out-of-range packet accepted
  } usd_strb_t;
endpackage

// File: rtl/usd_ctrl.sv
module usd_ctrl
  import usd_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int CORE_W = 2,
  parameter int ANT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LEN_W-1:0]  cfgLeft,
  input  logic [LEN_W-1:0]  cfgUseful,
  input  logic [LEN_W-1:0]  cfgRight,
  input  logic [CORE_W:0]   cfgCoreCount,
  input  logic              inValid,
  input  logic              inSop,
  input  logic [CORE_W-1:0] inCoreId,
  input  logic [ANT_W-1:0]  inAntId,
  input  logic              destOk,
  output logic              inReady,
  output usd_strb_t         strb,
  output logic [CORE_W-1:0] curCore,
  output logic [ANT_W-1:0]  curAnt
);
  localparam int EW = LEN_W + 2;

  logic [LEN_W-1:0]  posReg, curPos;
  logic [CORE_W-1:0] coreReg;
  logic [ANT_W-1:0]  antReg;
  logic              badReg, badNow;
  logic [EW-1:0]     posX, leftX, usefulEnd, pktEnd;
  logic              inUseful, atLastUseful, atLastSample, fire;

  always_comb begin
    curPos       = inSop ? '0 : posReg;
    posX         = {2'b00, curPos};
    leftX        = {2'b00, cfgLeft};
    usefulEnd    = leftX + {2'b00, cfgUseful};
    pktEnd       = usefulEnd + {2'b00, cfgRight};
    inUseful     = (posX >= leftX) && (posX < usefulEnd);
    atLastUseful = (posX == usefulEnd - EW'(1));
    atLastSample = (posX == pktEnd - EW'(1));
    badNow       = inSop ? ({1'b0, inCoreId} >= cfgCoreCount) : badReg;
    curCore      = inSop ? inCoreId : coreReg;
    curAnt       = inSop ? inAntId : antReg;
    inReady      = (inUseful && !badNow) ? destOk : 1'b1;
    fire         = inValid && inReady;

    strb.fire       = fire;
    strb.sop        = fire && inSop;
    strb.usefulGood = inUseful && !badNow;
    strb.lastUseful = atLastUseful;
    strb.badStart   = fire && inSop && badNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posReg  <= '0;
      coreReg <= '0;
      antReg  <= '0;
      badReg  <= 1'b0;
    end else if (fire) begin
      posReg <= atLastSample ? '0 : curPos + LEN_W'(1);
      if (inSop) begin
        coreReg <= inCoreId;
        antReg  <= inAntId;
        badReg  <= badNow;
      end
    end
  end
endmodule

// File: rtl/usd_dpath.sv
module usd_dpath
  import usd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_ANT   = 4,
  parameter int SAMPLE_W  = 16,
  parameter int NUM_SYM   = 7,
  parameter int PILOT_IDX = 3,
  parameter int CORE_W    = 2,
  parameter int ANT_W     = 2,
  parameter int SYM_W     = 3
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  usd_strb_t                       strb,
  input  logic [CORE_W-1:0]               curCore,
  input  logic [ANT_W-1:0]                curAnt,
  input  logic                            inSop,
  input  logic                            inSlotStart,
  input  logic                            inValid,
  input  logic [SAMPLE_W-1:0]             inData,
  input  logic [NUM_CORES-1:0]            dataReady,
  input  logic [NUM_CORES-1:0]            pilotReady,
  input  logic [NUM_CORES-1:0]            ntfReady,
  output logic                            destOk,
  output logic [NUM_CORES-1:0]            dataValid,
  output logic [NUM_CORES-1:0]            pilotValid,
  output logic [SAMPLE_W-1:0]             outSample,
  output logic [NUM_CORES-1:0]            ntfValid,
  output logic [ANT_W+SYM_W+CORE_W-1:0]   ntfWord,
  output logic                            errBadCore
);
  logic [SYM_W-1:0] symCnt [NUM_ANT];
  logic [SYM_W-1:0] symReg, curSym, nextSym;
  logic             isPilot, selReady, ntfPend, offer, ntfTake;

  always_comb begin
    curSym   = inSop ? (inSlotStart ? '0 : symCnt[curAnt]) : symReg;
    nextSym  = (curSym == SYM_W'(NUM_SYM - 1)) ? '0 : curSym + SYM_W'(1);
    isPilot  = (curSym == SYM_W'(PILOT_IDX));
    selReady = isPilot ? pilotReady[curCore] : dataReady[curCore];
    destOk   = !ntfPend && selReady;
    offer    = inValid && strb.usefulGood && !ntfPend;
    ntfTake  = |(ntfValid & ntfReady);
  end

  assign outSample = inData;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign dataValid[c]  = offer && !isPilot && (curCore == CORE_W'(c));
    assign pilotValid[c] = offer && isPilot && (curCore == CORE_W'(c));
    assign ntfValid[c]   = ntfPend && (ntfWord[CORE_W-1:0] == CORE_W'(c));
  end

  for (genvar a = 0; a < NUM_ANT; a++) begin : g_ant
    always_ff @(posedge clk) begin
      if (!rstN)
        symCnt[a] <= '0;
      else if (strb.sop && (curAnt == ANT_W'(a)))
        symCnt[a] <= nextSym;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      symReg     <= '0;
      ntfPend    <= 1'b0;
      ntfWord    <= '0;
      errBadCore <= 1'b0;
    end else begin
      if (strb.sop) symReg <= curSym;
      if (strb.badStart) errBadCore <= 1'b1;
      if (strb.fire && strb.usefulGood && strb.lastUseful) begin
        ntfPend <= 1'b1;
        ntfWord <= {curAnt, curSym, curCore};
      end else if (ntfTake) begin
        ntfPend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ul_symbol_dispatch.sv
module ul_symbol_dispatch
  import usd_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int NUM_ANT   = 4,
  parameter int SAMPLE_W  = 16,
  parameter int LEN_W     = 12,
  parameter int NUM_SYM   = 7,
  parameter int PILOT_IDX = 3,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int ANT_W    = (NUM_ANT > 1) ? $clog2(NUM_ANT) : 1,
  localparam int SYM_W    = $clog2(NUM_SYM),
  localparam int NTF_W    = ANT_W + SYM_W + CORE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [LEN_W-1:0]     cfgLeft,
  input  logic [LEN_W-1:0]     cfgUseful,
  input  logic [LEN_W-1:0]     cfgRight,
  input  logic [CORE_W:0]      cfgCoreCount,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic                 inSop,
  input  logic                 inSlotStart,
  input  logic [ANT_W-1:0]     inAntId,
  input  logic [CORE_W-1:0]    inCoreId,
  input  logic [SAMPLE_W-1:0]  inData,
  output logic [NUM_CORES-1:0] dataValid,
  input  logic [NUM_CORES-1:0] dataReady,
  output logic [NUM_CORES-1:0] pilotValid,
  input  logic [NUM_CORES-1:0] pilotReady,
  output logic [SAMPLE_W-1:0]  outSample,
  output logic [NUM_CORES-1:0] ntfValid,
  input  logic [NUM_CORES-1:0] ntfReady,
  output logic [NTF_W-1:0]     ntfWord,
  output logic                 errBadCore
);
  usd_strb_t         strb;
  logic [CORE_W-1:0] curCore;
  logic [ANT_W-1:0]  curAnt;
  logic              destOk;

  usd_ctrl #(.LEN_W(LEN_W), .CORE_W(CORE_W), .ANT_W(ANT_W)) u_ctrl (
    .clk, .rstN, .cfgLeft, .cfgUseful, .cfgRight, .cfgCoreCount,
    .inValid, .inSop, .inCoreId, .inAntId, .destOk,
    .inReady, .strb, .curCore, .curAnt
  );

  usd_dpath #(
    .NUM_CORES(NUM_CORES), .NUM_ANT(NUM_ANT), .SAMPLE_W(SAMPLE_W),
    .NUM_SYM(NUM_SYM), .PILOT_IDX(PILOT_IDX),
    .CORE_W(CORE_W), .ANT_W(ANT_W), .SYM_W(SYM_W)
  ) u_dpath (
    .clk, .rstN, .strb, .curCore, .curAnt, .inSop, .inSlotStart,
    .inValid, .inData, .dataReady, .pilotReady, .ntfReady,
    .destOk, .dataValid, .pilotValid, .outSample, .ntfValid,
    .ntfWord, .errBadCore
  );
endmodule

// File: rtl/usd_checks.sv
module usd_checks #(
  parameter int NUM_CORES = 4,
  parameter int NTF_W     = 7
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inReady,
  input logic [NUM_CORES-1:0] dataValid,
  input logic [NUM_CORES-1:0] dataReady,
  input logic [NUM_CORES-1:0] pilotValid,
  input logic [NUM_CORES-1:0] pilotReady,
  input logic [NUM_CORES-1:0] ntfValid,
  input logic [NUM_CORES-1:0] ntfReady,
  input logic [NTF_W-1:0]     ntfWord,
  input logic                 errBadCore
);
  // R6: at most one sample queue is offered a sample
  p_one_dest_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dataValid, pilotValid}));

  // R6: a refused offer stalls the input
  p_stall_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|(dataValid & ~dataReady) || |(pilotValid & ~pilotReady)) |-> !inReady);

  // R5: a waiting completion word is held
  p_ntf_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|(ntfValid & ~ntfReady)) |=> ($stable(ntfValid) && $stable(ntfWord)));

  // R5: only one core is notified at a time
  p_ntf_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ntfValid));

  // R5: a notification follows an accepted sample
  p_ntf_after_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|ntfValid) |-> $past(|(dataValid & dataReady) || |(pilotValid & pilotReady)));

  // R7: no sample offered while a completion word waits
  p_pend_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|ntfValid) |-> !(|dataValid || |pilotValid));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errBadCore |=> errBadCore);
endmodule

bind ul_symbol_dispatch usd_checks #(.NUM_CORES(NUM_CORES), .NTF_W(NTF_W)) u_chk (
  .clk(clk), .rstN(rstN), .inReady(inReady),
  .dataValid(dataValid), .dataReady(dataReady),
  .pilotValid(pilotValid), .pilotReady(pilotReady),
  .ntfValid(ntfValid), .ntfReady(ntfReady), .ntfWord(ntfWord),
  .errBadCore(errBadCore)
);

// File: tb/sim_ul_symbol_dispatch.sv
module sim_ul_symbol_dispatch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] cfgLeft = 12'd3, cfgUseful = 12'd5, cfgRight = 12'd2;
  logic [2:0]  cfgCoreCount = 3'd4;
  logic        inValid = 1'b0, inSop = 1'b0, inSlotStart = 1'b0;
  logic [1:0]  inAntId = '0, inCoreId = '0;
  logic [15:0] inData = '0;
  logic        inReady, errBadCore;
  logic [3:0]  dataValid, pilotValid, ntfValid;
  logic [3:0]  dataReady = '1, pilotReady = '1, ntfReady = '1;
  logic [15:0] outSample;
  logic [6:0]  ntfWord;

  always #10 clk = ~clk;

  ul_symbol_dispatch u0 (
    .clk, .rstN, .cfgLeft, .cfgUseful, .cfgRight, .cfgCoreCount,
    .inValid, .inReady, .inSop, .inSlotStart, .inAntId, .inCoreId, .inData,
    .dataValid, .dataReady, .pilotValid, .pilotReady, .outSample,
    .ntfValid, .ntfReady, .ntfWord, .errBadCore
  );

  int nChecks = 0, nFails = 0, cyc = 0, stallMode = 0;
  int bSym [4];
  bit expNtfPend = 0, doneFlag = 0;
  logic [6:0] expNtf = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic setReady();
    if (stallMode == 0) begin
      dataReady = '1; pilotReady = '1; ntfReady = '1;
    end else begin
      dataReady  = 4'(cyc ^ (cyc >> 2));
      pilotReady = 4'(~cyc);
      ntfReady   = {4{(cyc % 3) != 0}};
    end
  endtask

  // One clock of observation; act=1 means a sample is being presented
  task automatic cycleCheck(input bit act, input bit useful, input bit pilot,
                            input int core, input string gTag, output bit fired);
    logic [3:0] expD, expP;
    bit expRdy;
    setReady();
    @(negedge clk);
    if (act) begin
      if (useful) begin
        expRdy = !expNtfPend && (pilot ? pilotReady[core] : dataReady[core]);
        chk(inReady == expRdy, expNtfPend ? "R7" : "R6", inReady, expRdy);
      end else begin
        chk(inReady == 1'b1, gTag, inReady, 1);  // R1 guard or R8 drop
      end
    end
    expD = (act && useful && !expNtfPend && !pilot) ? 4'(1 << core) : 4'd0;
    expP = (act && useful && !expNtfPend && pilot)  ? 4'(1 << core) : 4'd0;
    chk(dataValid == expD, useful ? "R3" : gTag, dataValid, expD);
    chk(pilotValid == expP, useful ? "R3" : gTag, pilotValid, expP);
    if ((expD | expP) != 0) chk(outSample == inData, "R2", outSample, inData);
    chk(ntfValid == (expNtfPend ? 4'(1 << expNtf[1:0]) : 4'd0), "R5", ntfValid,
        expNtfPend ? (1 << expNtf[1:0]) : 0);
    if (expNtfPend) begin
      chk(ntfWord == expNtf, "R4", ntfWord, expNtf);
      if (ntfReady[expNtf[1:0]]) expNtfPend = 0;
    end
    fired = act && inReady;
    @(posedge clk); #1; cyc++;
  endtask

  task automatic sendPkt(input int ant, input int core, input bit slot, input string gTag);
    int total, sym;
    bit good, pilot;
    total = int'(cfgLeft) + int'(cfgUseful) + int'(cfgRight);
    sym = slot ? 0 : bSym[ant];       // R4 expected slot index
    bSym[ant] = (sym + 1) % 7;
    pilot = (sym == 3);
    good = (core < int'(cfgCoreCount));
    for (int i = 0; i < total; i++) begin
      bit useful, fired;
      useful = good && (i >= int'(cfgLeft)) && (i < int'(cfgLeft) + int'(cfgUseful));
      inValid = 1; inSop = (i == 0); inSlotStart = slot;
      inAntId = 2'(ant); inCoreId = 2'(core);
      inData = 16'(ant * 4096 + sym * 256 + core * 64 + i);
      fired = 0;
      while (!fired) begin
        cycleCheck(1, useful, pilot, core, good ? gTag : "R8", fired);
        if (fired && useful && i == int'(cfgLeft) + int'(cfgUseful) - 1) begin
          expNtfPend = 1;
          expNtf = {2'(ant), 3'(sym), 2'(core)};
        end
      end
    end
    inValid = 0; inSop = 0; inSlotStart = 0;
  endtask

  task automatic idle(input int n);
    bit f;
    for (int k = 0; k < n; k++) cycleCheck(0, 0, 0, 0, "R1", f);
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog actual 0 expected 1");
    finishUp();
  end

  initial begin
    for (int a = 0; a < 4; a++) bSym[a] = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R9 reset state
    chk(dataValid == 0 && pilotValid == 0, "R9", dataValid | pilotValid, 0);
    chk(ntfValid == 0, "R9", ntfValid, 0);
    chk(errBadCore == 0, "R9", errBadCore, 0);
    @(posedge clk); #1;

    // Sweep: 10 symbols per antenna, slot restart at 0 and 9 (wrap at 7)
    for (int s = 0; s < 10; s++)
      for (int a = 0; a < 4; a++)
        sendPkt(a, (a + s) % 4, (s == 0) || (s == 9), "R1");
    idle(3);

    // Same sweep under queue backpressure
    stallMode = 1;
    for (int s = 0; s < 9; s++)
      for (int a = 0; a < 4; a++)
        sendPkt(a, (a * 3 + s) % 4, s == 0, "R1");
    stallMode = 0;
    idle(3);

    // R10: no guard regions
    cfgLeft = 12'd0; cfgUseful = 12'd4; cfgRight = 12'd0;
    for (int s = 0; s < 8; s++)
      for (int a = 0; a < 4; a++)
        sendPkt(a, (s + 2 * a) % 4, s == 0, "R10");
    stallMode = 1;
    for (int s = 0; s < 7; s++) sendPkt(s % 4, s % 4, 0, "R10");
    stallMode = 0;
    idle(3);

    // R8: out-of-range core
    cfgLeft = 12'd2; cfgUseful = 12'd3; cfgRight = 12'd1; cfgCoreCount = 3'd3;
    sendPkt(1, 0, 1, "R1");
    idle(2);
    chk(errBadCore == 0, "R8", errBadCore, 0);
    sendPkt(1, 3, 0, "R8");
    idle(2);
    chk(errBadCore == 1, "R8", errBadCore, 1);
    // slot index advanced past dropped packet: next is index 2, then pilot 3
    sendPkt(1, 2, 0, "R8");
    sendPkt(1, 1, 0, "R8");
    idle(3);
    chk(errBadCore == 1, "R8", errBadCore, 1);
    finishUp();
  end
endmodule